// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The controller gathers five interrupt sources: two external pins, the overflow of two timers and a periodic time-base tick. Each source has a pending latch that only hardware can set. A latch is pending toward the CPU when its source is permitted by its mask bit and the global enable flip-flop is set. One source, external pin 0, ignores the masks. The highest-priority pending source is presented as a fixed vector address on a valid/ready pair.

When the CPU takes the request, the controller clears the enable and that source's latch. It then issues a push strobe, followed by a load-vector strobe together with a status-flag-set strobe. Return-from-interrupt sets the enable again. Software can write the masks. It can also issue one command that clears any chosen subset of latches and, optionally, sets the enable in the same cycle.

Back-pressure rules for the request channel are as follows. While `irq_ready` is low, no request is lost; the latches keep holding. `vec_addr` tracks the current best source, so it may move to a higher-priority one that arrives while the CPU waits. A transfer happens in a cycle where `irq_valid` and `irq_ready` are both high, and the vector taken is the one shown in that cycle. `irq_valid` may also drop without a transfer if software clears the latch or masks the source.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the enable, all masks and all latches are zero, and `irq_valid`, `push_stb`, `load_stb` and `sf_set` are low; a request latched before reset does not survive it.
- R2: Latch index i maps to a source and a vector as follows: 0 = external pin 0 at 002h, 1 = timer A overflow at 006h, 2 = timer B overflow at 008h, 3 = time-base tick at 00Ah, 4 = external pin 1 at 00Ch.
- R3: With several sources pending and permitted, the lowest latch index wins, so external pin 0 is highest.
- R4: Mask bit j (`mask_wdata[j]`, 1 = permit) governs latch j+1. External pin 0 is never masked.
- R5: No request is presented while the enable is 0. Setting the enable presents any source that is already pending.
- R6: A transfer clears the enable and the accepted latch at that edge. `push_stb` is high for the cycle after the transfer. The cycle after that has `load_stb` and `sf_set` high, with `vec_addr` equal to the accepted vector. Other latches are untouched.
- R7: A `reti` pulse sets the enable. If it coincides with a transfer, the transfer wins and the enable is cleared.
- R8: A `cmd_wr` clears exactly the latches whose `cmd_clr` bit is 1 and sets the enable when `cmd_set_en` is 1. Software can never set a latch.
- R9: External pins are synchronised through two flops and latched on a rising edge. The latch is set at the third clock edge after the pin rises. A pin held high does not re-latch after its latch is cleared.
- R10: A hardware capture in the same cycle as a clear of that latch, by software or by transfer, keeps the latch set.
- R11: A masked source stays latched and is presented once its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 2 | Asynchronous external interrupt pins (bit 0 = pin 0, bit 1 = pin 1) |
| tmr_a_ovf | input | 1 | Timer A overflow pulse, synchronous |
| tmr_b_ovf | input | 1 | Timer B overflow pulse, synchronous |
| tbase_tick | input | 1 | Time-base tick pulse, synchronous |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 4 | New mask bits, 1 = permit |
| cmd_wr | input | 1 | Command strobe: clear latches and optionally set enable |
| cmd_set_en | input | 1 | Set the enable with this command |
| cmd_clr | input | 5 | Latches to clear, one bit per latch index |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ready | input | 1 | CPU takes the presented request |
| irq_valid | output | 1 | A permitted request is presented |
| vec_addr | output | 13 | Presented vector; the accepted vector during `load_stb` |
| push_stb | output | 1 | Push PC and flags |
| load_stb | output | 1 | Load `vec_addr` into PC |
| sf_set | output | 1 | Set the status flag to 1 |

## Verification
The hardest situation to reach is a hardware capture landing in the very cycle its latch is being cleared. The timer pulses are synchronous, so the bench drives a timer pulse on the same clock edge as a software clear of that latch, then checks that the request is still presented. The accept sequence is observed cycle by cycle from the transfer edge through the load strobe. A lower-priority source left pending then has to stay hidden until `reti`, which shows the transfer cleared only the winner.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int PC_W    = 13;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PUSH, SEQ_LOAD} seq_t;

  // vector of latch index: 0 -> 002h, then 4 + 2*idx
  function automatic logic [PC_W-1:0] vec_of(input int idx);
    return (idx == 0) ? PC_W'(2) : PC_W'(4 + 2 * idx);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = irq_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // capture beats a simultaneous clear
    p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> lat[i]);
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !lat[i]);
    p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat[i] && !set[i]) |=> !lat[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]    req,
  output logic [N-1:0]    grant,
  output logic            any,
  output logic [PC_W-1:0] vec
);
  always_comb begin
    grant = '0;
    vec   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec      = vec_of(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ext_irq,
  input  logic               tmr_a_ovf,
  input  logic               tmr_b_ovf,
  input  logic               tbase_tick,
  input  logic               mask_wr,
  input  logic [NUM_SRC-2:0] mask_wdata,
  input  logic               cmd_wr,
  input  logic               cmd_set_en,
  input  logic [NUM_SRC-1:0] cmd_clr,
  input  logic               reti,
  input  logic               irq_ready,
  output logic               irq_valid,
  output logic [PC_W-1:0]    vec_addr,
  output logic               push_stb,
  output logic               load_stb,
  output logic               sf_set
);
  logic [1:0]         ext_rise;
  logic [NUM_SRC-1:0] hw_set, clr_all, lat, req, grant;
  logic [NUM_SRC-2:0] mask_q;
  logic               en_q, any, accept;
  logic [PC_W-1:0]    best_vec, vec_q;
  seq_t               seq_q;

  for (genvar k = 0; k < 2; k++) begin : g_sync
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_irq[k]), .rise(ext_rise[k])
    );
  end

  assign hw_set  = {ext_rise[1], tbase_tick, tmr_b_ovf, tmr_a_ovf, ext_rise[0]};
  assign clr_all = (cmd_wr ? cmd_clr : '0) | (accept ? grant : '0);

  irq_latch_bank #(.N(NUM_SRC)) u_lat (
    .clk(clk), .rst_n(rst_n), .set(hw_set), .clr(clr_all), .lat(lat)
  );

  // latch 0 bypasses the masks
  assign req = lat & {mask_q, 1'b1};

  irq_prio_enc #(.N(NUM_SRC)) u_enc (
    .req(req), .grant(grant), .any(any), .vec(best_vec)
  );

  assign irq_valid = (seq_q == SEQ_IDLE) && en_q && any;
  assign accept    = irq_valid && irq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      seq_q  <= SEQ_IDLE;
      vec_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (accept)                          en_q <= 1'b0;
      else if (reti || (cmd_wr && cmd_set_en)) en_q <= 1'b1;
      case (seq_q)
        SEQ_IDLE: if (accept) begin
          seq_q <= SEQ_PUSH;
          vec_q <= best_vec;
        end
        SEQ_PUSH: seq_q <= SEQ_LOAD;
        default:  seq_q <= SEQ_IDLE;
      endcase
    end
  end

  assign push_stb = (seq_q == SEQ_PUSH);
  assign load_stb = (seq_q == SEQ_LOAD);
  assign sf_set   = load_stb;
  assign vec_addr = load_stb ? vec_q : (any ? best_vec : '0);

  p_accept_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !en_q);
  p_accept_then_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> push_stb);
  p_push_then_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_stb |=> (load_stb && sf_set));
  p_reti_sets_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !accept) |=> en_q);
  p_valid_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reti && !cmd_wr) |=> !irq_valid);
  p_unmaskable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && lat[0] && seq_q == SEQ_IDLE) |-> (irq_valid && vec_addr == PC_W'(2)));
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ext_irq = '0;
  logic        tmr_a_ovf = 0, tmr_b_ovf = 0, tbase_tick = 0;
  logic        mask_wr = 0, cmd_wr = 0, cmd_set_en = 0, reti = 0, irq_ready = 0;
  logic [3:0]  mask_wdata = '0;
  logic [4:0]  cmd_clr = '0;
  logic        irq_valid, push_stb, load_stb, sf_set;
  logic [12:0] vec_addr;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_a_ovf(tmr_a_ovf),
    .tmr_b_ovf(tmr_b_ovf), .tbase_tick(tbase_tick), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .cmd_wr(cmd_wr), .cmd_set_en(cmd_set_en),
    .cmd_clr(cmd_clr), .reti(reti), .irq_ready(irq_ready),
    .irq_valid(irq_valid), .vec_addr(vec_addr), .push_stb(push_stb),
    .load_stb(load_stb), .sf_set(sf_set)
  );

  // {mask, source pattern (bit i = latch i), expected valid, expected vector}
  localparam logic [22:0] TBL [13] = '{
    {4'hF, 5'b00001, 1'b1, 13'h002},
    {4'hF, 5'b00010, 1'b1, 13'h006},
    {4'hF, 5'b00100, 1'b1, 13'h008},
    {4'hF, 5'b01000, 1'b1, 13'h00A},
    {4'hF, 5'b10000, 1'b1, 13'h00C},
    {4'hF, 5'b11111, 1'b1, 13'h002},
    {4'hF, 5'b11110, 1'b1, 13'h006},
    {4'hF, 5'b11000, 1'b1, 13'h00A},
    {4'h0, 5'b11110, 1'b0, 13'h000},
    {4'h0, 5'b10001, 1'b1, 13'h002},
    {4'hE, 5'b00110, 1'b1, 13'h008},
    {4'h7, 5'b10000, 1'b0, 13'h000},
    {4'h8, 5'b11110, 1'b1, 13'h00C}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic set_en, input logic [4:0] clr);
    @(negedge clk); cmd_wr = 1; cmd_set_en = set_en; cmd_clr = clr;
    @(negedge clk); cmd_wr = 0; cmd_set_en = 0; cmd_clr = '0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); mask_wr = 1; mask_wdata = m;
    @(negedge clk); mask_wr = 0;
  endtask

  // fire a source pattern; returns at a negedge after all latches are set
  task automatic fire(input logic [4:0] pat);
    @(negedge clk);
    ext_irq = {pat[4], pat[0]};
    tmr_a_ovf = pat[1]; tmr_b_ovf = pat[2]; tbase_tick = pat[3];
    @(negedge clk); tmr_a_ovf = 0; tmr_b_ovf = 0; tbase_tick = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pins_low();
    ext_irq = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", irq_valid, 0);
    chk("R1 push", push_stb, 0);
    chk("R1 load", load_stb, 0);
    chk("R1 sf", sf_set, 0);

    // R5 pending but enable off
    fire(5'b00001); pins_low();
    chk("R5 no valid without enable", irq_valid, 0);
    cmd(1'b1, 5'b00000);
    chk("R5 valid after enable", irq_valid, 1);
    chk("R5 vector", vec_addr, 13'h002);
    cmd(1'b0, 5'b11111);

    // table walk: R2 R3 R4
    foreach (TBL[i]) begin
      set_mask(TBL[i][22:19]);
      fire(TBL[i][18:14]);
      chk($sformatf("R2/R3/R4 row %0d valid", i), irq_valid, TBL[i][13]);
      if (TBL[i][13]) chk($sformatf("R2/R3 row %0d vector", i), vec_addr, TBL[i][12:0]);
      pins_low();
      cmd(1'b0, 5'b11111);
    end

    // R6 accept sequence with timer A and B pending
    set_mask(4'hF);
    fire(5'b00110);
    irq_ready = 1;
    @(negedge clk); irq_ready = 0;
    chk("R6 enable cleared", irq_valid, 0);
    chk("R6 push", push_stb, 1);
    chk("R6 no load yet", load_stb, 0);
    @(negedge clk);
    chk("R6 load", load_stb, 1);
    chk("R6 sf", sf_set, 1);
    chk("R6 load vector", vec_addr, 13'h006);
    chk("R6 push done", push_stb, 0);
    @(negedge clk);
    chk("R6 sequence ends", load_stb, 0);
    chk("R6 still disabled", irq_valid, 0);
    // R7 return sets enable; timer B latch kept
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    chk("R7 valid after reti", irq_valid, 1);
    chk("R6 other latch kept", vec_addr, 13'h008);

    // R8 selective clear and no software set
    fire(5'b01000);
    cmd(1'b0, 5'b00100);
    chk("R8 selective clear", vec_addr, 13'h00A);
    cmd(1'b0, 5'b11111);
    chk("R8 all cleared", irq_valid, 0);
    cmd(1'b1, 5'b00000);
    chk("R8 no software set", irq_valid, 0);

    // R10 capture beats clear in same cycle
    @(negedge clk); tmr_a_ovf = 1; cmd_wr = 1; cmd_clr = 5'b00010;
    @(negedge clk); tmr_a_ovf = 0; cmd_wr = 0; cmd_clr = '0;
    chk("R10 capture kept", irq_valid, 1);
    chk("R10 vector", vec_addr, 13'h006);
    cmd(1'b0, 5'b11111);

    // R9 synchroniser latency and held level
    @(negedge clk); ext_irq[1] = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet after two edges", irq_valid, 0);
    @(negedge clk);
    chk("R9 latched at third edge", irq_valid, 1);
    chk("R9 vector", vec_addr, 13'h00C);
    cmd(1'b0, 5'b10000);
    repeat (5) @(negedge clk);
    chk("R9 held level no relatch", irq_valid, 0);
    pins_low();

    // R11 masked source stays latched
    set_mask(4'h0);
    fire(5'b01000);
    chk("R11 masked hidden", irq_valid, 0);
    set_mask(4'h4);
    chk("R11 unmasked shows", vec_addr, 13'h00A);
    chk("R11 valid", irq_valid, 1);

    // R1 reset clears pending latch, enable and masks
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 valid after reset", irq_valid, 0);
    cmd(1'b1, 5'b00000);
    set_mask(4'hF);
    chk("R1 latches cleared by reset", irq_valid, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule